// File: doc/BRIEF.md
# Time-of-Day Alarm Interrupt Controller

This block watches the running minutes, hours and day-of-week of a real-time clock and raises a time-of-day alarm when they agree with three programmable alarm registers. Each alarm register carries a mask bit in bit 7. The masks widen the comparison, so the alarm can fire once a week, once a day, once an hour or on every minute boundary. The time counting itself lives outside the block. The block is given the current time fields plus two one-cycle strobes: one marks the cycle in which hundredths reads 99, and the other marks that the seconds are about to wrap from 59 to 00.

A raised alarm sets a read-only flag. The flag drives an active-low interrupt on one of two outputs. The other output carries an interrupt request from a companion watchdog, and a configuration bit swaps the two outputs. In level mode the flag holds until software touches any alarm register. In pulse mode it stays up for a fixed number of clock cycles and then drops by itself. Any read or write of an alarm register clears the flag. A separate mask input keeps the alarm off the pins while the flag still records the event.

Top module: `tod_alarm_irq`

## Requirements
- R1: The alarm registers sit at bus addresses 3 (minutes), 5 (hours) and 7 (day), and bit 7 of each is its mask bit. Minutes and hours read back all eight bits as written. The day register reads back bit 7 and bits 2:0, and bits 6:3 always read 0. Any other address reads 0x00.
- R2: With all three masks clear, an alarm fires only when the minutes (bits 6:0), the hours (bits 5:0) and the day (bits 2:0) all equal the current time.
- R3: With only the day mask set, an alarm fires when the minutes and the hours match, whatever the day.
- R4: With the day and hour masks set and the minutes mask clear, an alarm fires when the minutes match.
- R5: With all three masks set, an alarm fires on every minute boundary.
- R6: A mask bit takes effect only if every coarser field is also masked, in the order day, then hours, then minutes. Any other combination acts like the listed pattern that has fewer masks set.
- R7: The hour comparison covers bits 5:0. In 12-hour mode this includes the AM/PM bit, so 11 AM does not match an 11 PM alarm.
- R8: An alarm is evaluated only in a cycle where `hund_tick` and `sec_wrap` are both high. `tod_flag` rises at the next clock edge.
- R9: A read or a write of address 3, 5 or 7 clears `tod_flag` and the alarm interrupt at the next edge. The clear wins over an alarm that is evaluated in the same cycle.
- R10: In level mode (`cfg_pulse`=0) the flag stays set until an alarm register is accessed.
- R11: In pulse mode (`cfg_pulse`=1) the flag stays high for exactly PULSE_CYCLES cycles and then clears by itself.
- R12: While `cfg_tod_mask`=1, the alarm interrupt output stays inactive (high), but `tod_flag` still sets.
- R13: Both interrupt outputs are active low. With `cfg_swap`=1, `irq_a_n` carries the alarm and `irq_b_n` carries `wd_irq`. With `cfg_swap`=0, the two are exchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD (bit 5 is AM/PM in 12-hour mode) |
| cur_day | input | 3 | Current day of week |
| hund_tick | input | 1 | Strobe: hundredths reads 99 |
| sec_wrap | input | 1 | Strobe: seconds are about to roll from 59 to 00 |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| cfg_swap | input | 1 | 1: alarm on A and watchdog on B; 0: exchanged |
| cfg_pulse | input | 1 | 1: pulse mode; 0: level mode |
| cfg_tod_mask | input | 1 | 1: suppress the alarm interrupt output |
| wd_irq | input | 1 | Watchdog interrupt request, active high |
| tod_flag | output | 1 | Read-only alarm flag |
| irq_a_n | output | 1 | Interrupt output A, active low |
| irq_b_n | output | 1 | Interrupt output B, active low |

## Verification
Random trials cover every combination of the mask bits, including the four combinations outside the listed patterns. A design that decoded the masks independently would fire hourly alarms on the wrong minute or ignore hours that should count. Directed cases cover four more faults. An hour compare that dropped the AM/PM bit would fire twice a day. A design that evaluated on either strobe alone would fire sixty or a hundred times too often. An access that lost to a same-cycle alarm would leave a stale flag. The pulse case counts the flag width cycle by cycle, so a timer that is off by one cycle is caught.

// File: rtl/tod_alarm_pkg.sv
// Shared constants and helpers for the time-of-day alarm controller.
// Assumes 8-bit registers with the mask bit in bit 7 of every alarm field.
package tod_alarm_pkg;

    localparam int unsigned REG_W      = 8;
    localparam int unsigned NUM_FIELDS = 3;   // 0: minutes, 1: hours, 2: day
    localparam int unsigned MASK_BIT   = 7;

    // Bus address of alarm field f (minutes 3, hours 5, day 7).
    function automatic int unsigned field_addr(input int unsigned f);
        return 3 + 2 * f;
    endfunction

    // Bits that a field keeps on write; the rest read back as 0.
    function automatic logic [REG_W-1:0] field_keep(input int unsigned f);
        return (f == 2) ? 8'h87 : 8'hFF;
    endfunction

endpackage

// File: rtl/tod_alarm_regs.sv
// Alarm register file: three mask+value fields on a simple strobe bus.
// Assumes bus_wr/bus_rd are single-cycle strobes; read data is combinational.
// Flags any read or write of an alarm field through alm_access.
module tod_alarm_regs
    import tod_alarm_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 bus_wr,
    input  logic                                 bus_rd,
    input  logic [ADDR_W-1:0]                    bus_addr,
    input  logic [REG_W-1:0]                     bus_wdata,
    output logic [REG_W-1:0]                     bus_rdata,
    output logic                                 alm_access,
    output logic [NUM_FIELDS-1:0][REG_W-1:0]     field_q
);

    logic [NUM_FIELDS-1:0] hit_vec;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        logic [REG_W-1:0] q;

        assign hit_vec[f] = (bus_addr == ADDR_W'(field_addr(f)));

        // Store the written value, keeping only the bits this field owns.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (bus_wr && hit_vec[f]) begin
                q <= bus_wdata & field_keep(f);
            end
        end

        assign field_q[f] = q;
    end

    // Read mux: the addressed field, or zero when no field is hit.
    always_comb begin
        bus_rdata = '0;
        for (int f = 0; f < NUM_FIELDS; f++) begin
            if (hit_vec[f]) begin
                bus_rdata = field_q[f];
            end
        end
    end

    // Any access to a field counts as a flag-clearing touch.
    assign alm_access = (bus_wr || bus_rd) && (|hit_vec);

endmodule

// File: rtl/tod_alarm_match.sv
// Alarm comparator: decides whether the evaluation cycle raises an alarm.
// Assumes the current-time inputs already hold the values to be compared
// in the cycle where both strobes are high. A mask only counts when every
// coarser field is masked too (day > hours > minutes).
module tod_alarm_match
    import tod_alarm_pkg::*;
(
    input  logic             hund_tick,
    input  logic             sec_wrap,
    input  logic [REG_W-1:0] alm_min,
    input  logic [REG_W-1:0] alm_hour,
    input  logic [REG_W-1:0] alm_day,
    input  logic [6:0]       cur_min,
    input  logic [5:0]       cur_hour,
    input  logic [2:0]       cur_day,
    output logic             alarm_event
);

    logic ign_day, ign_hour, ign_min;
    logic min_ok, hour_ok, day_ok;

    // Effective masks: each field may be ignored only below an ignored field.
    always_comb begin
        ign_day  = alm_day[MASK_BIT];
        ign_hour = ign_day  && alm_hour[MASK_BIT];
        ign_min  = ign_hour && alm_min[MASK_BIT];
    end

    // Per-field agreement, widened by the effective masks.
    always_comb begin
        min_ok  = ign_min  || (alm_min[6:0]  == cur_min);
        hour_ok = ign_hour || (alm_hour[5:0] == cur_hour);
        day_ok  = ign_day  || (alm_day[2:0]  == cur_day);
    end

    // An event needs the evaluation slot and every field in agreement.
    always_comb begin
        alarm_event = hund_tick && sec_wrap && min_ok && hour_ok && day_ok;
    end

endmodule

// File: rtl/tod_alarm_flag.sv
// Alarm flag keeper with level and pulse behaviour.
// Assumes PULSE_CYCLES >= 1 clock cycles cover the required pulse time.
// A register access always wins over a same-cycle alarm event.
module tod_alarm_flag #(
    parameter int unsigned PULSE_CYCLES = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic alarm_event,
    input  logic alm_access,
    input  logic cfg_pulse,
    output logic tod_flag
);

    localparam int unsigned CNT_W = $clog2(PULSE_CYCLES + 1);

    logic [CNT_W-1:0] pulse_cnt;

    // Set on event, clear on access, or time out in pulse mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tod_flag  <= 1'b0;
            pulse_cnt <= '0;
        end else if (alm_access) begin
            tod_flag  <= 1'b0;
            pulse_cnt <= '0;
        end else if (alarm_event) begin
            tod_flag  <= 1'b1;
            pulse_cnt <= CNT_W'(PULSE_CYCLES);
        end else if (tod_flag && cfg_pulse) begin
            if (pulse_cnt <= CNT_W'(1)) begin
                tod_flag  <= 1'b0;
                pulse_cnt <= '0;
            end else begin
                pulse_cnt <= pulse_cnt - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/tod_irq_route.sv
// Interrupt output router: masks the alarm and steers alarm and watchdog
// requests onto the two active-low outputs. Purely combinational.
module tod_irq_route (
    input  logic tod_flag,
    input  logic cfg_tod_mask,
    input  logic cfg_swap,
    input  logic wd_irq,
    output logic irq_a_n,
    output logic irq_b_n
);

    logic tod_req;

    // Alarm request that survives the output mask.
    always_comb begin
        tod_req = tod_flag && !cfg_tod_mask;
    end

    // Steer the two requests to the pins, inverting for active low.
    always_comb begin
        if (cfg_swap) begin
            irq_a_n = !tod_req;
            irq_b_n = !wd_irq;
        end else begin
            irq_a_n = !wd_irq;
            irq_b_n = !tod_req;
        end
    end

endmodule

// File: rtl/tod_alarm_irq.sv
// Top of the maskable time-of-day alarm interrupt controller.
// Assumes the time source supplies the strobes and fields in the same cycle.
// Joins the register file, comparator, flag keeper and output router.
module tod_alarm_irq
    import tod_alarm_pkg::*;
#(
    parameter int unsigned ADDR_W       = 4,
    parameter int unsigned PULSE_CYCLES = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [6:0]        cur_min,
    input  logic [5:0]        cur_hour,
    input  logic [2:0]        cur_day,
    input  logic              hund_tick,
    input  logic              sec_wrap,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              cfg_swap,
    input  logic              cfg_pulse,
    input  logic              cfg_tod_mask,
    input  logic              wd_irq,
    output logic              tod_flag,
    output logic              irq_a_n,
    output logic              irq_b_n
);

    logic [NUM_FIELDS-1:0][REG_W-1:0] field_q;
    logic [REG_W-1:0]                 alm_min, alm_hour, alm_day;
    logic                             alm_access;
    logic                             alarm_event;

    assign alm_min  = field_q[0];
    assign alm_hour = field_q[1];
    assign alm_day  = field_q[2];

    tod_alarm_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .alm_access (alm_access),
        .field_q    (field_q)
    );

    tod_alarm_match u_match (
        .hund_tick   (hund_tick),
        .sec_wrap    (sec_wrap),
        .alm_min     (alm_min),
        .alm_hour    (alm_hour),
        .alm_day     (alm_day),
        .cur_min     (cur_min),
        .cur_hour    (cur_hour),
        .cur_day     (cur_day),
        .alarm_event (alarm_event)
    );

    tod_alarm_flag #(.PULSE_CYCLES(PULSE_CYCLES)) u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .alarm_event (alarm_event),
        .alm_access  (alm_access),
        .cfg_pulse   (cfg_pulse),
        .tod_flag    (tod_flag)
    );

    tod_irq_route u_route (
        .tod_flag     (tod_flag),
        .cfg_tod_mask (cfg_tod_mask),
        .cfg_swap     (cfg_swap),
        .wd_irq       (wd_irq),
        .irq_a_n      (irq_a_n),
        .irq_b_n      (irq_b_n)
    );

endmodule

// File: rtl/tod_alarm_irq_chk.sv
// Property checker for tod_alarm_irq, attached through bind below.
// Observes ports plus the stored alarm fields; drives nothing.
module tod_alarm_irq_chk #(
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hund_tick,
    input logic              sec_wrap,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_rdata,
    input logic              cfg_swap,
    input logic              cfg_pulse,
    input logic              cfg_tod_mask,
    input logic              wd_irq,
    input logic              tod_flag,
    input logic              irq_a_n,
    input logic              irq_b_n,
    input logic [7:0]        alm_min,
    input logic [7:0]        alm_hour,
    input logic [7:0]        alm_day
);

    logic touch;
    assign touch = (bus_wr || bus_rd) &&
                   (bus_addr == ADDR_W'(3) || bus_addr == ADDR_W'(5) || bus_addr == ADDR_W'(7));

    p_day_pad_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(7)) |-> (bus_rdata[6:3] == 4'b0000));

    p_every_minute_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hund_tick && sec_wrap && alm_min[7] && alm_hour[7] && alm_day[7] && !touch)
        |=> tod_flag);

    p_rise_needs_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tod_flag) |-> $past(hund_tick && sec_wrap));

    p_access_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> !tod_flag);

    p_level_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tod_flag && !cfg_pulse && !touch) |=> tod_flag);

    p_mask_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_tod_mask && !wd_irq) |-> (irq_a_n && irq_b_n));

    p_route_a_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_swap && tod_flag && !cfg_tod_mask) |-> !irq_a_n);

    p_route_b_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_swap && tod_flag && !cfg_tod_mask) |-> !irq_b_n);

endmodule

bind tod_alarm_irq tod_alarm_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hund_tick    (hund_tick),
    .sec_wrap     (sec_wrap),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .cfg_swap     (cfg_swap),
    .cfg_pulse    (cfg_pulse),
    .cfg_tod_mask (cfg_tod_mask),
    .wd_irq       (wd_irq),
    .tod_flag     (tod_flag),
    .irq_a_n      (irq_a_n),
    .irq_b_n      (irq_b_n),
    .alm_min      (alm_min),
    .alm_hour     (alm_hour),
    .alm_day      (alm_day)
);

// File: tb/test_tod_alarm_irq.sv
// Bench for tod_alarm_irq: directed corners plus seeded random mask trials.
module test_tod_alarm_irq;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;
    localparam int PULSE      = 6;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [6:0]        cur_min;
    logic [5:0]        cur_hour;
    logic [2:0]        cur_day;
    logic              hund_tick, sec_wrap;
    logic              bus_wr, bus_rd;
    logic [ADDR_W-1:0] bus_addr;
    logic [7:0]        bus_wdata, bus_rdata;
    logic              cfg_swap, cfg_pulse, cfg_tod_mask, wd_irq;
    logic              tod_flag, irq_a_n, irq_b_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tod_alarm_irq #(.ADDR_W(ADDR_W), .PULSE_CYCLES(PULSE)) i_tod_alarm_irq (
        .clk(clk), .rst_n(rst_n), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_day(cur_day), .hund_tick(hund_tick), .sec_wrap(sec_wrap),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_swap(cfg_swap),
        .cfg_pulse(cfg_pulse), .cfg_tod_mask(cfg_tod_mask), .wd_irq(wd_irq),
        .tod_flag(tod_flag), .irq_a_n(irq_a_n), .irq_b_n(irq_b_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected alarm outcome from the mask table (day, hours, minutes).
    function automatic logic exp_match(input logic [7:0] am, ah, ad,
                                       input logic [6:0] cm, input logic [5:0] ch,
                                       input logic [2:0] cd);
        logic m_eq, h_eq, d_eq;
        m_eq = (am[6:0] == cm);
        h_eq = (ah[5:0] == ch);
        d_eq = (ad[2:0] == cd);
        if (!ad[7])      return m_eq && h_eq && d_eq;
        else if (!ah[7]) return m_eq && h_eq;
        else if (!am[7]) return m_eq;
        else             return 1'b1;
    endfunction

    function automatic string req_of(input logic d, h, m);
        case ({d, h, m})
            3'b000:  return "R2";
            3'b100:  return "R3";
            3'b110:  return "R4";
            3'b111:  return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic bus_write(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0;
    endtask

    task automatic bus_read(input int a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = ADDR_W'(a);
        #(CLK_PERIOD/4);
        d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = '0;
    endtask

    // Drive the strobes for one cycle; return at the following negedge.
    task automatic fire(input logic h, input logic s);
        @(negedge clk);
        hund_tick = h; sec_wrap = s;
        @(negedge clk);
        hund_tick = 1'b0; sec_wrap = 1'b0;
    endtask

    function automatic logic [6:0] rnd_min();
        return {3'($urandom % 6), 4'($urandom % 10)};
    endfunction

    function automatic logic [5:0] rnd_hour();
        int v;
        v = $urandom % 24;
        return {2'(v / 10), 4'(v % 10)};
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cur_min = '0; cur_hour = '0; cur_day = '0;
        hund_tick = 0; sec_wrap = 0; bus_wr = 0; bus_rd = 0; bus_addr = '0;
        bus_wdata = '0; cfg_swap = 1; cfg_pulse = 0; cfg_tod_mask = 0; wd_irq = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        chk("R9 reset flag", 32'(tod_flag), 0);
        chk("R13 reset irq_a_n", 32'(irq_a_n), 1);
        chk("R13 reset irq_b_n", 32'(irq_b_n), 1);

        // R1: layout and read-back
        bus_write(3, 8'hD9); bus_read(3, rd); chk("R1 minutes readback", 32'(rd), 32'hD9);
        bus_write(5, 8'hFF); bus_read(5, rd); chk("R1 hours readback", 32'(rd), 32'hFF);
        bus_write(7, 8'hFF); bus_read(7, rd); chk("R1 day pad bits", 32'(rd), 32'h87);
        bus_read(4, rd); chk("R1 unmapped address", 32'(rd), 32'h00);

        // R8: neither strobe alone evaluates (every-minute masks set)
        fire(1, 0); chk("R8 hund_tick alone", 32'(tod_flag), 0);
        fire(0, 1); chk("R8 sec_wrap alone", 32'(tod_flag), 0);
        fire(1, 1); chk("R8 both strobes", 32'(tod_flag), 1);

        // R10: level mode holds
        repeat (20) @(negedge clk);
        chk("R10 level hold", 32'(tod_flag), 1);

        // R12: mask hides the alarm but keeps the flag
        cfg_tod_mask = 1; #1;
        chk("R12 masked irq_a_n", 32'(irq_a_n), 1);
        chk("R12 flag kept", 32'(tod_flag), 1);
        cfg_tod_mask = 0; #1;
        chk("R13 swap=1 alarm on A", 32'(irq_a_n), 0);
        cfg_swap = 0; wd_irq = 1; #1;
        chk("R13 swap=0 alarm on B", 32'(irq_b_n), 0);
        chk("R13 swap=0 watchdog on A", 32'(irq_a_n), 0);
        wd_irq = 0; #1;
        chk("R13 swap=0 A idle", 32'(irq_a_n), 1);
        cfg_swap = 1;

        // R9: read clears; access beats same-cycle event
        bus_read(5, rd); chk("R9 read clears flag", 32'(tod_flag), 0);
        @(negedge clk);
        hund_tick = 1; sec_wrap = 1; bus_wr = 1; bus_addr = ADDR_W'(7); bus_wdata = 8'hFF;
        @(negedge clk);
        hund_tick = 0; sec_wrap = 0; bus_wr = 0; bus_addr = '0;
        chk("R9 access wins over event", 32'(tod_flag), 0);

        // R11: pulse width
        cfg_pulse = 1;
        begin
            int high;
            high = 0;
            fire(1, 1);
            for (int i = 0; i < PULSE + 4; i++) begin
                if (tod_flag) high++;
                @(negedge clk);
            end
            chk("R11 pulse width", 32'(high), 32'(PULSE));
            chk("R11 pulse ended", 32'(tod_flag), 0);
        end
        cfg_pulse = 0;

        // R7: AM/PM bit participates (daily alarm at 11 PM, 12-hour)
        bus_write(3, 8'h30); bus_write(5, 8'h71); bus_write(7, 8'h82);
        cur_min = 7'h30; cur_hour = 6'h11; cur_day = 3'd5;
        fire(1, 1); chk("R7 11 AM vs 11 PM alarm", 32'(tod_flag), 0);
        cur_hour = 6'h31;
        fire(1, 1); chk("R7 11 PM matches", 32'(tod_flag), 1);
        bus_read(3, rd);

        // Random mask/time trials (R2..R6, R9, R12, R13)
        for (int t = 0; t < 300; t++) begin
            logic [7:0] am, ah, ad;
            logic       e, treq;
            am = {1'($urandom), rnd_min()};
            ah = {1'($urandom), 1'($urandom), rnd_hour()};
            ad = {1'($urandom), 4'b0, 3'(1 + $urandom % 7)};
            bus_write(3, am); bus_write(5, ah); bus_write(7, ad);
            cur_min  = ($urandom % 2) ? am[6:0] : rnd_min();
            cur_hour = ($urandom % 2) ? ah[5:0] : rnd_hour();
            cur_day  = ($urandom % 2) ? ad[2:0] : 3'(1 + $urandom % 7);
            cfg_swap = 1'($urandom); cfg_tod_mask = 1'($urandom); wd_irq = 1'($urandom);
            e = exp_match(am, ah, ad, cur_min, cur_hour, cur_day);
            fire(1, 1);
            chk(req_of(ad[7], ah[7], am[7]), 32'(tod_flag), 32'(e));
            treq = e && !cfg_tod_mask;
            chk("R13 irq_a_n", 32'(irq_a_n), 32'(!(cfg_swap ? treq : wd_irq)));
            chk("R12 irq_b_n", 32'(irq_b_n), 32'(!(cfg_swap ? wd_irq : treq)));
            bus_read(3 + 2 * ($urandom % 3), rd);
            chk("R9 access clears", 32'(tod_flag), 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule